// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers one-cycle event pulses from a serial peripheral core (transmit FIFO empty, half-empty and underrun, receive FIFO full and overrun, and two fault conditions) into sticky status bits. Each status bit is masked by its own enable bit. The OR of the masked bits is then gated by one global enable to form a single level-sensitive interrupt line. Software acknowledges an event by writing a one to its status bit. A status bit keeps latching events while the global enable is off, so software clears stale bits before it turns the global enable on.

Software reaches three 32-bit registers through a request channel with valid/ready. `req_ready` is held high, so a request is accepted in every cycle in which `req_valid` is high and the requester never stalls. A read returns its data on `rsp_valid`/`rsp_data` one cycle after acceptance. There is no response channel back-pressure, so the requester must take the data in that cycle. A write produces no response. The interrupt output is registered.

Top module: `irq_agg_unit`

## Requirements
- R1: An active-low asynchronous reset clears the status, enable and global-enable registers and drives `irq_o` and `rsp_valid` low. After reset, every register reads as zero.
- R2: A pulse on `evt_pulse[n]` sets status bit n whatever the enables and global enable hold. The bit positions are: 0 mode fault, 1 selected-as-slave fault, 2 TX empty, 3 TX underrun, 4 RX full, 5 RX overrun, 6 TX half empty. The bit stays set until it is cleared.
- R3: A write to the status register at offset 0x20 clears each status bit whose write-data bit is one. Bits written with zero keep their value. Writing back a value read from the register clears exactly the bits that were set.
- R4: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends set.
- R5: The enable register at offset 0x28 stores write-data bits 6:0. It reads back those seven bits, and bits 31:7 read as zero.
- R6: The global-enable register at offset 0x1C stores only write-data bit 31 and reads back as 0x80000000 or 0. Writes that leave bit 31 at zero turn the global enable off.
- R7: One cycle after the registers change, `irq_o` equals the global enable ANDed with the OR over all seven sources of (status AND enable).
- R8: An accepted read (`req_valid` high, `req_write` low) raises `rsp_valid` for exactly one cycle in the following cycle. `rsp_data` then carries the register value from before that edge. Unmapped offsets read zero, and writes to them change nothing.
- R9: `req_ready` is high in every cycle, and an accepted write raises no `rsp_valid`.
- R10: The status register reads zero in bits 31:7, and a write to it never sets a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| evt_pulse | input | 7 | Event pulses from the core, one bit per source |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
A status latch that drops or invents a bit is visible on the very next read of offset 0x20. One cycle later it also shows on `irq_o` whenever that source is enabled and the global enable is on. A wrong enable or global-enable value shows on the next read of its register. It also moves `irq_o` in the cycle after a pending source is unmasked or masked. The bench checks the same-cycle event/clear collision, stale events seen under a disabled global enable, and writes whose ones fall only in unused bits. Each of these shows at the ports within two cycles.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned SRC_COUNT = 7;

  typedef enum int unsigned {
    SRC_MODE_FAULT  = 0,
    SRC_SEL_FAULT   = 1,
    SRC_TX_EMPTY    = 2,
    SRC_TX_UNDERRUN = 3,
    SRC_RX_FULL     = 4,
    SRC_RX_OVERRUN  = 5,
    SRC_TX_HALF     = 6
  } src_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_GIE  = 2'd1,
    SEL_STS  = 2'd2,
    SEL_ENA  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] sts_o
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bit_q <= 1'b0;
      else if (evt_i[i])  bit_q <= 1'b1;
      else if (clr_i[i])  bit_q <= 1'b0;
    end
    assign sts_o[i] = bit_q;

    // R4: an event sets the bit even when a clear hits it in the same cycle
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> bit_q);
    // R3: a clear without a new event empties the bit
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !evt_i[i]) |=> !bit_q);
    // R2: a set bit stays set until it is cleared
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_q && !clr_i[i]) |=> bit_q);
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SRC_N   = 7,
  parameter logic [ADDR_W-1:0] GIE_OFS = 8'h1C,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h20,
  parameter logic [ADDR_W-1:0] ENA_OFS = 8'h28,
  parameter int unsigned GIE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [SRC_N-1:0]  sts_i,
  output logic [SRC_N-1:0]  clr_o,
  output logic [SRC_N-1:0]  ena_o,
  output logic              gie_o
);
  localparam int unsigned PAD_W = DATA_W - SRC_N;

  reg_sel_e          sel;
  logic              acc_wr, acc_rd;
  logic [SRC_N-1:0]  ena_q;
  logic              gie_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign req_ready = 1'b1;
  assign acc_wr    = req_valid &&  req_write;
  assign acc_rd    = req_valid && !req_write;
  assign unused_wdata = ^req_wdata;

  always_comb begin
    if      (req_addr == GIE_OFS) sel = SEL_GIE;
    else if (req_addr == STS_OFS) sel = SEL_STS;
    else if (req_addr == ENA_OFS) sel = SEL_ENA;
    else                          sel = SEL_NONE;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_GIE: rd_mux[GIE_BIT] = gie_q;
      SEL_STS: rd_mux = {{PAD_W{1'b0}}, sts_i};
      SEL_ENA: rd_mux = {{PAD_W{1'b0}}, ena_q};
      default: rd_mux = '0;
    endcase
  end

  assign clr_o = (acc_wr && sel == SEL_STS) ? req_wdata[SRC_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      gie_q <= 1'b0;
    end else if (acc_wr) begin
      if (sel == SEL_ENA) ena_q <= req_wdata[SRC_N-1:0];
      if (sel == SEL_GIE) gie_q <= req_wdata[GIE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_data <= rd_mux;
    end
  end

  assign ena_o = ena_q;
  assign gie_o = gie_q;

  // R8: every accepted read is answered in the next cycle
  a_r8_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);
  // R9: no response without a read
  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rsp_valid);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] sts_i,
  input  logic [SRC_N-1:0] ena_i,
  input  logic             gie_i,
  output logic             irq_o
);
  logic [SRC_N-1:0] masked;
  logic             any_pending;

  assign masked      = sts_i & ena_i;
  assign any_pending = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= gie_i && any_pending;
  end

  // R7: the global enable off forces the line low one cycle later
  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_o);
  // R7: an enabled pending source with global enable on raises the line
  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && ($countones(sts_i & ena_i) != 0)) |=> irq_o);
endmodule

// File: rtl/irq_agg_unit.sv
module irq_agg_unit #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SRC_N   = irq_agg_pkg::SRC_COUNT,
  parameter logic [ADDR_W-1:0] GIE_OFS = 8'h1C,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h20,
  parameter logic [ADDR_W-1:0] ENA_OFS = 8'h28,
  parameter int unsigned GIE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [SRC_N-1:0]  evt_pulse,
  output logic              irq_o
);
  logic [SRC_N-1:0] sts, clr, ena;
  logic             gie;

  irq_reg_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_N(SRC_N),
    .GIE_OFS(GIE_OFS), .STS_OFS(STS_OFS), .ENA_OFS(ENA_OFS), .GIE_BIT(GIE_BIT)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sts_i(sts), .clr_o(clr), .ena_o(ena), .gie_o(gie)
  );

  irq_status_bank #(.SRC_N(SRC_N)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .clr_i(clr), .sts_o(sts)
  );

  irq_combine #(.SRC_N(SRC_N)) u_comb (
    .clk(clk), .rst_n(rst_n), .sts_i(sts), .ena_i(ena), .gie_i(gie), .irq_o(irq_o)
  );
endmodule

// File: tb/test_irq_agg_unit.sv
module test_irq_agg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [6:0]  evt_pulse = '0;
  logic        irq_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_agg_unit i_irq_agg_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .evt_pulse(evt_pulse), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // fields: req[84:81] wr[80] addr[79:72] wdata[71:40] evt[39:33] exp_rd[32:1] exp_irq[0]
  localparam int NV = 27;
  localparam logic [84:0] VEC [NV] = '{
    {4'd1,  1'b0, 8'h20, 32'h0,        7'h00, 32'h0,        1'b0}, // R1 status zero
    {4'd1,  1'b0, 8'h28, 32'h0,        7'h00, 32'h0,        1'b0}, // R1 enable zero
    {4'd1,  1'b0, 8'h1C, 32'h0,        7'h00, 32'h0,        1'b0}, // R1 gie zero
    {4'd5,  1'b1, 8'h28, 32'hFFFFFFFF, 7'h00, 32'h0,        1'b0}, // R5 write all ones
    {4'd5,  1'b0, 8'h28, 32'h0,        7'h00, 32'h0000007F, 1'b0}, // R5 read 7 bits
    {4'd2,  1'b0, 8'h20, 32'h0,        7'h04, 32'h0,        1'b0}, // R2 TX empty, gie off
    {4'd2,  1'b0, 8'h20, 32'h0,        7'h00, 32'h00000004, 1'b0}, // R2 latched
    {4'd6,  1'b1, 8'h1C, 32'h7FFFFFFF, 7'h00, 32'h0,        1'b0}, // R6 bit31 zero
    {4'd6,  1'b0, 8'h1C, 32'h0,        7'h00, 32'h0,        1'b0}, // R6
    {4'd7,  1'b1, 8'h1C, 32'h80000000, 7'h00, 32'h0,        1'b1}, // R7 stale fires
    {4'd6,  1'b0, 8'h1C, 32'h0,        7'h00, 32'h80000000, 1'b1}, // R6 readback
    {4'd3,  1'b1, 8'h20, 32'h00000004, 7'h00, 32'h0,        1'b0}, // R3 ack
    {4'd3,  1'b0, 8'h20, 32'h0,        7'h00, 32'h0,        1'b0}, // R3
    {4'd8,  1'b0, 8'h30, 32'h0,        7'h41, 32'h0,        1'b1}, // R8 unmapped read
    {4'd4,  1'b1, 8'h20, 32'h00000001, 7'h01, 32'h0,        1'b1}, // R4 collision
    {4'd4,  1'b0, 8'h20, 32'h0,        7'h00, 32'h00000041, 1'b1}, // R4 bit kept
    {4'd3,  1'b1, 8'h20, 32'h00000040, 7'h00, 32'h0,        1'b1}, // R3 only bit 6
    {4'd7,  1'b1, 8'h28, 32'h00000002, 7'h00, 32'h0,        1'b0}, // R7 masked
    {4'd7,  1'b0, 8'h28, 32'h0,        7'h02, 32'h00000002, 1'b1}, // R7 enabled src
    {4'd8,  1'b1, 8'h24, 32'hFFFFFFFF, 7'h00, 32'h0,        1'b1}, // R8 unmapped write
    {4'd8,  1'b0, 8'h20, 32'h0,        7'h00, 32'h00000003, 1'b1}, // R8 no effect
    {4'd10, 1'b1, 8'h20, 32'hFFFFFF80, 7'h00, 32'h0,        1'b1}, // R10 upper ones
    {4'd10, 1'b0, 8'h20, 32'h0,        7'h00, 32'h00000003, 1'b1}, // R10 unchanged
    {4'd3,  1'b1, 8'h20, 32'hFFFFFFFF, 7'h00, 32'h0,        1'b0}, // R3 clear all
    {4'd6,  1'b1, 8'h1C, 32'h0,        7'h00, 32'h0,        1'b0}, // R6 gie off
    {4'd2,  1'b0, 8'h20, 32'h0,        7'h7F, 32'h0,        1'b0}, // R2 all sources
    {4'd2,  1'b0, 8'h20, 32'h0,        7'h00, 32'h0000007F, 1'b0}  // R2 positions
  };

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [6:0] e, output logic rv, output logic [31:0] rd,
                      output logic iq);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; evt_pulse = e;
    @(posedge clk); #1;
    rv = rsp_valid; rd = rsp_data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; evt_pulse = '0;
    @(posedge clk); #1;
    iq = irq_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic rv, iq;
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "irq in reset", {31'b0, irq_o}, 32'h0);
    chk("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    chk("R9", "ready in reset", {31'b0, req_ready}, 32'h1);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      string tag;
      logic [84:0] v;
      v = VEC[k];
      tag = $sformatf("R%0d", v[84:81]);
      step(v[80], v[79:72], v[71:40], v[39:33], rv, rd, iq);
      chk(v[80] ? "R9" : "R8", $sformatf("rsp_valid step %0d", k), {31'b0, rv}, {31'b0, !v[80]});
      if (!v[80]) chk(tag, $sformatf("read data step %0d", k), rd, v[32:1]);
      chk(tag, $sformatf("irq step %0d", k), {31'b0, iq}, {31'b0, v[0]});
      chk("R9", "ready", {31'b0, req_ready}, 32'h1);
    end

    // R8: rsp_valid lasts exactly one cycle
    step(1'b0, 8'h20, 32'h0, 7'h00, rv, rd, iq);
    chk("R8", "rsp_valid drops after one cycle", {31'b0, rsp_valid}, 32'h0);

    // R1: reset in the middle of activity
    step(1'b1, 8'h28, 32'h7F, 7'h00, rv, rd, iq);
    step(1'b1, 8'h1C, 32'h80000000, 7'h10, rv, rd, iq);
    chk("R7", "irq before mid reset", {31'b0, iq}, 32'h1);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1", "irq async clear", {31'b0, irq_o}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 8'h20, 32'h0, 7'h00, rv, rd, iq);
    chk("R1", "status after reset", rd, 32'h0);
    step(1'b0, 8'h28, 32'h0, 7'h00, rv, rd, iq);
    chk("R1", "enable after reset", rd, 32'h0);
    step(1'b0, 8'h1C, 32'h0, 7'h00, rv, rd, iq);
    chk("R1", "gie after reset", rd, 32'h0);
    chk("R1", "irq after reset", {31'b0, iq}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule